// File: doc/BRIEF.md
# Display Attribute Intensity Modulator

This block decides, for each of the character positions of a multiplexed dot-matrix display, whether that position's column drivers may conduct during the current display cycle. It takes a display-cycle tick, the 8-bit attribute control word and a per-character flash vector. From these it builds a per-digit drive-enable vector and a flag that tells the font path to force every dot of every character on. Row scanning, font decoding and the analog drivers sit outside it.

Intensity is set by duty cycle alone. Each 15-tick frame has a number of lit slots that depends on a 3-bit brightness level, so the peak drive level never changes. A slow square wave comes from a tick divider with a 50% duty cycle. Per-character flashing and whole-display blinking both gate the drive with this one wave, so they stay in phase. Reset restarts the wave so that several displays reset together blink in step. Lamp test overrides everything else.

Control word fields used: bits [2:0] brightness level, bit 3 character-flash enable, bit 4 whole-display blink, bit 5 spare, bit 6 lamp test, bit 7 clear (handled by another block).

Top module: `disp_attr_mod`

## Requirements
- R1: The brightness level in control bits [2:0] sets how many slots of a 15-slot frame are lit: 0→15, 1→12, 2→8, 3→6, 4→4, 5→3, 6→2, 7→0. A digit can be enabled only in slot numbers below that count.
- R2: The slot number starts at 0 after reset. It advances by one on each cycle with `tick` high and wraps from 14 back to 0.
- R3: The flash/blink wave is high after reset. It inverts after every HALF_TICKS ticks, which gives a 50% duty cycle.
- R4: When control bit 3 is 1, each digit whose `flash` bit is 1 is disabled while the wave is low. Digits whose flash bit is 0 are not affected.
- R5: When control bit 4 is 1, all digits are disabled while the wave is low, whatever the flash bits are.
- R6: When control bit 6 is 1, `lamp_force` is 1 and every digit is enabled in slots 0 to 7 and disabled in slots 8 to 14 (53%). Brightness, flash and blink have no effect during lamp test. When bit 6 is 0, `lamp_force` is 0.
- R7: Control bits 5 and 7 have no effect on either output.
- R8: With no tick, the slot number and the wave hold their values, so the outputs change only when the control word or the flash vector changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the frame and the wave |
| tick | input | 1 | Display-cycle strobe, one clock wide |
| ctrl | input | 8 | Attribute control word |
| flash | input | NDIG | Per-digit flash bits |
| drive_en | output | NDIG | Per-digit column-drive enable for the current slot |
| lamp_force | output | 1 | Force all dots of every character on |

## Verification
The assertions assume that `tick` is a clean single-clock strobe and that `ctrl` and `flash` are steady at the clock edges where they are sampled. The bench changes its inputs only on the falling clock edge and pulses `tick` for one cycle. The random stimulus covers every brightness level together with flash, blink, lamp test and the spare bits. Directed sequences cover the blank level, full brightness, lamp test over a blanked display, and idle stretches without ticks. A short HALF_TICKS that does not line up with the 15-slot frame makes both wave phases occur in every slot.

// File: rtl/dam_pkg.sv
package dam_pkg;
  localparam int FRAME_SLOTS = 15;
  localparam int LAMP_SLOTS  = 8;

  typedef struct packed {
    logic       clear;
    logic       lamp;
    logic       spare;
    logic       blink;
    logic       cflash;
    logic [2:0] level;
  } ctrl_t;

  // lit slots per 15-slot frame for each brightness level
  function automatic int lit_slots(input logic [2:0] lvl);
    case (lvl)
      3'd0:    return 15;
      3'd1:    return 12;
      3'd2:    return 8;
      3'd3:    return 6;
      3'd4:    return 4;
      3'd5:    return 3;
      3'd6:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/dam_duty.sv
module dam_duty #(
  parameter int FRAME = 15,
  parameter int SW    = $clog2(FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [SW-1:0] slot,
  output logic          frame_wrap
);
  localparam logic [SW-1:0] LAST = SW'(FRAME - 1);

  assign frame_wrap = tick && (slot == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          slot <= '0;
    else if (frame_wrap) slot <= '0;
    else if (tick)       slot <= slot + 1'b1;
  end

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && slot == LAST) |=> (slot == '0)); // R2
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(slot)); // R8
endmodule

// File: rtl/dam_rate.sv
module dam_rate #(
  parameter int HALF_TICKS = 64,
  parameter int CW         = $clog2(HALF_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic wave,
  output logic wave_flip
);
  localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);
  logic [CW-1:0] cnt;

  assign wave_flip = tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      wave <= 1'b1;
    end else if (wave_flip) begin
      cnt  <= '0;
      wave <= ~wave;
    end else if (tick) begin
      cnt  <= cnt + 1'b1;
    end
  end

  AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wave_flip |=> $stable(wave)); // R8
  AST_WAVE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    wave_flip |=> (wave != $past(wave))); // R3
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt <= LAST)); // R3
endmodule

// File: rtl/dam_gate.sv
module dam_gate (
  input  logic bright_on,
  input  logic lamp_on,
  input  logic lamp,
  input  logic blink_en,
  input  logic flash_en,
  input  logic flash_bit,
  input  logic wave,
  output logic en
);
  logic blink_gate, flash_gate;

  assign blink_gate = !blink_en || wave;
  assign flash_gate = !(flash_en && flash_bit) || wave;

  always_comb begin
    if (lamp) en = lamp_on;
    else      en = bright_on && blink_gate && flash_gate;
  end

  always_comb begin
    if (lamp == 1'b0 && bright_on == 1'b0)
      AST_DARK_SLOT: assert (en == 1'b0); // R1
  end
endmodule

// File: rtl/disp_attr_mod.sv
module disp_attr_mod #(
  parameter int NDIG       = 8,
  parameter int HALF_TICKS = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [7:0]      ctrl,
  input  logic [NDIG-1:0] flash,
  output logic [NDIG-1:0] drive_en,
  output logic            lamp_force
);
  import dam_pkg::*;
  localparam int SW = $clog2(FRAME_SLOTS);

  ctrl_t         cw;
  logic [SW-1:0] slot;
  logic          frame_wrap, wave, wave_flip;
  logic          bright_on, lamp_on;

  assign cw = ctrl_t'(ctrl);

  dam_duty #(.FRAME(FRAME_SLOTS), .SW(SW)) u_duty (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .slot(slot), .frame_wrap(frame_wrap)
  );

  dam_rate #(.HALF_TICKS(HALF_TICKS)) u_rate (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wave(wave), .wave_flip(wave_flip)
  );

  assign bright_on  = int'(slot) < lit_slots(cw.level);
  assign lamp_on    = int'(slot) < LAMP_SLOTS;
  assign lamp_force = cw.lamp;

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    dam_gate u_gate (
      .bright_on(bright_on), .lamp_on(lamp_on), .lamp(cw.lamp),
      .blink_en(cw.blink), .flash_en(cw.cflash), .flash_bit(flash[d]),
      .wave(wave), .en(drive_en[d])
    );
  end

  AST_LAMP_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_force |-> ($countones(drive_en) == 0 || $countones(drive_en) == NDIG)); // R6
  AST_BLANK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] == 1'b0 && ctrl[2:0] == 3'd7) |-> (drive_en == '0)); // R1
  AST_BLINK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] == 1'b0 && ctrl[4] && !wave) |-> (drive_en == '0)); // R5
  AST_FLASH_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] == 1'b0 && ctrl[3] && !wave) |-> ((drive_en & flash) == '0)); // R4
  AST_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] == 1'b0 && ctrl[4:0] == 5'd0) |-> (drive_en == '1)); // R1
  AST_WAVE_EDGE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (wave != $past(wave)) |-> $past(tick)); // R3
endmodule

// File: tb/tb_disp_attr_mod.sv
module tb_disp_attr_mod;
  localparam int NDIG = 8;
  localparam int HALF = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tick = 1'b0;
  logic [7:0]      ctrl = 8'h00;
  logic [NDIG-1:0] flash = '0;
  logic [NDIG-1:0] drive_en;
  logic            lamp_force;

  int checks = 0;
  int fails  = 0;
  int m_slot = 0;
  int m_wcnt = 0;
  bit m_wave = 1'b1;

  always #5 clk = ~clk;

  disp_attr_mod #(.NDIG(NDIG), .HALF_TICKS(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl(ctrl), .flash(flash),
    .drive_en(drive_en), .lamp_force(lamp_force)
  );

  function automatic int lit_for(input int lvl);
    int t[8] = '{15, 12, 8, 6, 4, 3, 2, 0};
    return t[lvl];
  endfunction

  function automatic logic [NDIG-1:0] exp_drive(input int s, input bit w,
                                                input logic [7:0] c,
                                                input logic [NDIG-1:0] f);
    logic [NDIG-1:0] r;
    if (c[6]) return (s < 8) ? '1 : '0;
    if (s >= lit_for(int'(c[2:0]))) return '0;
    if (c[4] && !w) return '0;
    r = '1;
    if (c[3] && !w) r = ~f;
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (slot=%0d wave=%0d ctrl=%h flash=%h)",
               tag, act, expv, m_slot, m_wave, ctrl, flash);
    end
  endtask

  task automatic cmp(input string tag);
    #1;
    check(tag, 32'(drive_en), 32'(exp_drive(m_slot, m_wave, ctrl, flash)));
    check({tag, "/R6"}, 32'(lamp_force), 32'(ctrl[6]));
  endtask

  task automatic step(input bit t);
    tick = t;
    @(posedge clk);
    if (t) begin
      m_slot = (m_slot == 14) ? 0 : m_slot + 1;
      if (m_wcnt == HALF - 1) begin m_wcnt = 0; m_wave = !m_wave; end
      else m_wcnt++;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin : watchdog
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int seed;
    seed = 32'h5eed1;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R3 reset state: slot 0, wave high, full brightness
    cmp("R2_reset");
    check("R3_reset_all_on", 32'(drive_en), 32'hff);

    // R1 full and blank levels across a whole frame
    for (int i = 0; i < 15; i++) begin ctrl = 8'h00; cmp("R1_full"); step(1); end
    for (int i = 0; i < 15; i++) begin ctrl = 8'h07; cmp("R1_blank"); step(1); end

    // R6 lamp test over a blanked, blinking, flashing setting
    flash = 8'h5a;
    for (int i = 0; i < 30; i++) begin ctrl = 8'h5f; cmp("R6_lamp"); step(1); end

    // R5 blink ignores flash bits; R4 flash only hits selected digits
    for (int i = 0; i < 30; i++) begin ctrl = 8'h10; flash = 8'h00; cmp("R5_blink"); step(1); end
    for (int i = 0; i < 30; i++) begin ctrl = 8'h08; flash = 8'hc3; cmp("R4_flash"); step(1); end

    // R7 spare and clear bits have no effect
    for (int i = 0; i < 30; i++) begin
      ctrl = 8'ha9; flash = 8'h0f; cmp("R7_spare_clear");
      ctrl = 8'h09; cmp("R7_ref"); step(1);
    end

    // R8 no tick: state holds while inputs change
    for (int i = 0; i < 40; i++) begin
      ctrl = 8'($urandom); flash = 8'($urandom); cmp("R8_hold"); step(0);
    end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      ctrl = 8'($urandom); flash = 8'($urandom);
      if (($urandom % 4) == 0) ctrl[6] = 1'b0;
      cmp("R1_R4_R5_random");
      step(($urandom % 5) != 0);
    end

    // R3 reset mid-run restarts wave and frame
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    m_slot = 0; m_wcnt = 0; m_wave = 1'b1;
    for (int i = 0; i < 20; i++) begin ctrl = 8'h10; flash = '0; cmp("R3_rerun"); step(1); end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule